// File: doc/BRIEF.md
# Bit-Serial Dual-Bank Radix Sorter

This block puts a fixed-size array of unsigned integers into ascending order with a least-significant-bit-first binary radix sort that moves the data back and forth between two on-chip memory banks. The words are first streamed into bank A, one per cycle while `in_valid` is high. A pulse on `start` then runs the sort. For every bit position, from bit 0 up to the most significant bit, the controller walks the source bank twice in address order. On the first walk it copies every word that has a 0 in the current bit into the other bank. On the second walk it appends, behind those, every word that has a 1 in that bit. The two banks then swap roles and the next bit is processed.

Every pass has the same length whatever the data, so the run time is fixed: one bank read is issued per cycle, over 2·W·L cycles, followed by one drain cycle. When the sort finishes, `done` goes high and `result_bank` shows which bank holds the sorted array. That bank is always A for an even word width and B for an odd one. A consumer then reads the array through `rd_addr`/`rd_data`. Both banks have registered read ports, and the write-back stage is delayed by exactly that one cycle of read latency.

Top module: `radix_sorter`

## Requirements
- R1: After reset, `busy`, `done` and `result_bank` are all 0.
- R2: While `busy` is 0, each cycle with `in_valid` high writes `in_data` into bank A. The write address starts at 0, goes up by one per accepted word and wraps from L-1 back to 0. An accepted `start` returns this address to 0, so a later load begins at address 0 again.
- R3: A `start` seen while the block is idle or done begins a sort. On the next cycle `busy` is 1 and `done` is 0.
- R4: When `done` is 1, addresses 0 to L-1 of the result bank hold the loaded words in non-decreasing unsigned order, with duplicates kept. During every bit step exactly L words are written into the destination bank.
- R5: `done` rises exactly 2·W·L+1 clock edges after the edge that accepted `start`, whatever the data values.
- R6: While `done` is 1, `result_bank` is 0 (bank A) when W is even and 1 (bank B) when W is odd.
- R7: When the block is not busy, `rd_data` shows the word of the bank named by `result_bank` at the address that was on `rd_addr` one clock edge earlier.
- R8: While `busy` is 1, `in_valid` and `start` have no effect. The sort timing, the sorted result and the next load address do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load strobe; writes in_data into bank A |
| in_data | input | W | Word being loaded |
| start | input | 1 | Begins a sort of bank A |
| busy | output | 1 | A sort is in progress |
| done | output | 1 | Sort finished; result readable |
| result_bank | output | 1 | Bank that holds the sorted array (0 = A, 1 = B) |
| rd_addr | input | clog2(L) | Read address into the result bank |
| rd_data | output | W | Registered read data, one cycle after rd_addr |

## Verification
The bench feeds arrays that are already sorted, reversed, full of duplicates, all zeros and nearly all ones. A design that dropped or doubled words when the write pointer crosses between the zero pass and the one pass would lose or repeat values in some of these. It counts the cycles to `done` on every array, so a design whose timing depends on the data, or whose read and write stages are out of step by a cycle, fails the timing check. A second instance with an odd width checks that the result ends up in bank B. Other directed cases drive load and start strobes in the middle of a sort, load more than L words so that the address wraps, and load a word after a sort to show that the load address was returned to 0. A design that accepted strobes while busy, or kept a stale load pointer, would corrupt bank A in these cases.

// File: rtl/radix_sort_pkg.sv
package radix_sort_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } sort_state_t;
endpackage

// File: rtl/radix_bank.sv
module radix_bank #(
   parameter int W = 8,
   parameter int L = 8
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [$clog2(L)-1:0] waddr,
   input  logic [W-1:0]         wdata,
   input  logic [$clog2(L)-1:0] raddr,
   output logic [W-1:0]         rdata
);
   logic [W-1:0] mem [L];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/radix_seq.sv
module radix_seq import radix_sort_pkg::*; #(
   parameter int W = 8,
   parameter int L = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   output logic                 launch,
   output logic                 issue,
   output logic                 first,
   output logic                 pass,
   output logic                 src,
   output logic [$clog2(L)-1:0] idx,
   output logic [$clog2(W)-1:0] bitpos,
   output logic                 busy,
   output logic                 done
);
   localparam int AW = $clog2(L);
   localparam int BW = $clog2(W);
   localparam int TOTAL = 2 * W * L;
   localparam int CW = $clog2(TOTAL + 1) + 1;

   sort_state_t state;

   assign issue  = (state == ST_RUN);
   assign busy   = (state == ST_RUN) || (state == ST_DRAIN);
   assign done   = (state == ST_DONE);
   assign launch = start && ((state == ST_IDLE) || (state == ST_DONE));
   assign first  = issue && (idx == '0) && !pass;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         pass   <= 1'b0;
         bitpos <= '0;
         src    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state  <= ST_RUN;
                  idx    <= '0;
                  pass   <= 1'b0;
                  bitpos <= '0;
                  src    <= 1'b0;
               end
            end
            ST_RUN: begin
               if (idx == AW'(L - 1)) begin
                  idx  <= '0;
                  pass <= ~pass;
                  if (pass) begin
                     src <= ~src;
                     if (bitpos == BW'(W - 1)) begin
                        bitpos <= '0;
                        state  <= ST_DRAIN;
                     end else begin
                        bitpos <= bitpos + 1'b1;
                     end
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   // cycle counter for the run-length check
   logic [CW-1:0] run_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)      run_cnt <= '0;
      else if (launch) run_cnt <= '0;
      else if (issue)  run_cnt <= run_cnt + 1'b1;
   end

   assert_run_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (run_cnt == CW'(TOTAL)));

   assert_start_begins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (busy && !done));
endmodule

// File: rtl/radix_sorter.sv
module radix_sorter #(
   parameter int W = 8,
   parameter int L = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [W-1:0]         in_data,
   input  logic                 start,
   output logic                 busy,
   output logic                 done,
   output logic                 result_bank,
   input  logic [$clog2(L)-1:0] rd_addr,
   output logic [W-1:0]         rd_data
);
   localparam int AW = $clog2(L);
   localparam int BW = $clog2(W);
   localparam int PW = AW + 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("radix_sorter: W must be at least 2");
      end
      if (L < 2) begin : g_bad_length
         $error("radix_sorter: L must be at least 2");
      end
   endgenerate

   logic          launch, issue, first, pass, src;
   logic [AW-1:0] idx;
   logic [BW-1:0] bitpos;

   radix_seq #(.W(W), .L(L)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .launch (launch),
      .issue  (issue),
      .first  (first),
      .pass   (pass),
      .src    (src),
      .idx    (idx),
      .bitpos (bitpos),
      .busy   (busy),
      .done   (done)
   );

   assign result_bank = src;

   // write-stage copy of the read-stage controls, one cycle behind
   logic          p_valid, p_first, p_pass, p_src;
   logic [BW-1:0] p_bit;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_valid <= 1'b0;
         p_first <= 1'b0;
         p_pass  <= 1'b0;
         p_src   <= 1'b0;
         p_bit   <= '0;
      end else begin
         p_valid <= issue;
         p_first <= first;
         p_pass  <= pass;
         p_src   <= src;
         p_bit   <= bitpos;
      end
   end

   logic [W-1:0]  bank_q [2];
   logic          bank_we [2];
   logic [AW-1:0] bank_waddr [2];
   logic [W-1:0]  bank_wdata [2];
   logic [AW-1:0] raddr;

   assign raddr   = issue ? idx : rd_addr;
   assign rd_data = p_src ? bank_q[1] : bank_q[0];

   logic          load_we, sw_en, sw_dst;
   logic [AW-1:0] load_ptr, sw_addr;
   logic [PW-1:0] wr_ptr;

   assign load_we = in_valid && !busy;
   assign sw_en   = p_valid && (rd_data[p_bit] == p_pass);
   assign sw_dst  = ~p_src;
   assign sw_addr = p_first ? '0 : wr_ptr[AW-1:0];

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_bank
         logic sort_hit;
         assign sort_hit = sw_en && (sw_dst == 1'(g));
         if (g == 0) begin : g_load_port
            assign bank_we[g]    = sort_hit || load_we;
            assign bank_waddr[g] = sort_hit ? sw_addr : load_ptr;
            assign bank_wdata[g] = sort_hit ? rd_data : in_data;
         end else begin : g_sort_port
            assign bank_we[g]    = sort_hit;
            assign bank_waddr[g] = sw_addr;
            assign bank_wdata[g] = rd_data;
         end
         radix_bank #(.W(W), .L(L)) u_bank (
            .clk   (clk),
            .we    (bank_we[g]),
            .waddr (bank_waddr[g]),
            .wdata (bank_wdata[g]),
            .raddr (raddr),
            .rdata (bank_q[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  wr_ptr <= '0;
      else if (sw_en)              wr_ptr <= PW'(sw_addr) + 1'b1;
      else if (p_valid && p_first) wr_ptr <= '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       load_ptr <= '0;
      else if (launch)  load_ptr <= '0;
      else if (load_we) load_ptr <= (load_ptr == AW'(L - 1)) ? '0 : load_ptr + 1'b1;
   end

   assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && !p_first) |-> (wr_ptr < PW'(L)));

   assert_bit_step_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && p_first && (p_bit != '0)) |-> (wr_ptr == PW'(L)));

   assert_final_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (wr_ptr == PW'(L)));

   assert_load_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_valid) |=> $stable(load_ptr));

   assert_result_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result_bank == ((W % 2) == 1)));
endmodule

// File: tb/tb_radix_sorter.sv
module tb_radix_sorter;
   localparam int W = 8;
   localparam int L = 8;
   localparam int NV = 6;
   localparam int OW = 3;
   localparam int OL = 4;

   localparam logic [W*L-1:0] VECS [NV] = '{
      64'h0807060504030201,
      64'h0102030405060708,
      64'hFF00FF0080808080,
      64'h3C9A1E7705D2B461,
      64'h0000000000000000,
      64'hFFFFFFFFFFFFFFFE
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         in_valid = 1'b0, start = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [2:0]   rd_addr = '0;
   logic         busy, done, result_bank;
   logic [W-1:0] rd_data;

   radix_sorter #(.W(W), .L(L)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .start(start), .busy(busy), .done(done), .result_bank(result_bank),
      .rd_addr(rd_addr), .rd_data(rd_data));

   logic          o_valid = 1'b0, o_start = 1'b0;
   logic [OW-1:0] o_data = '0;
   logic [1:0]    o_addr = '0;
   logic          o_busy, o_done, o_bank;
   logic [OW-1:0] o_rd;

   radix_sorter #(.W(OW), .L(OL)) dut_odd (
      .clk(clk), .rst_n(rst_n), .in_valid(o_valid), .in_data(o_data),
      .start(o_start), .busy(o_busy), .done(o_done), .result_bank(o_bank),
      .rd_addr(o_addr), .rd_data(o_rd));

   int checks = 0;
   int fails = 0;
   logic [W-1:0] ref_w [L];

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ref_sort();
      for (int i = 1; i < L; i++) begin
         logic [W-1:0] key = ref_w[i];
         int j = i - 1;
         while (j >= 0 && ref_w[j] > key) begin
            ref_w[j + 1] = ref_w[j];
            j--;
         end
         ref_w[j + 1] = key;
      end
   endtask

   task automatic load(input logic [W-1:0] v);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = v;
   endtask

   // start the sort, count edges to done; optionally poke strobes mid-run (R8)
   task automatic run_sort(input bit poke, output int n);
      @(negedge clk);
      in_valid = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R3 busy after start", busy, 1);
      check("R3 done cleared", done, 0);
      n = 0;
      while (!done && n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (poke && n == 4) begin
            start = 1'b1; in_valid = 1'b1; in_data = 8'hAA;
         end else if (poke && n == 5) begin
            start = 1'b0; in_valid = 1'b0;
         end
      end
   endtask

   task automatic read_all(input string req);
      for (int a = 0; a < L; a++) begin
         @(negedge clk);
         rd_addr = a[2:0];
         @(negedge clk);
         check(req, rd_data, ref_w[a]);
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy reset", busy, 0);
      check("R1 done reset", done, 0);
      check("R1 result_bank reset", result_bank, 0);

      // vector table: one loop over all arrays
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < L; i++) begin
            ref_w[i] = VECS[v][W*i +: W];
            load(VECS[v][W*i +: W]);
         end
         run_sort(v == 0, n);
         check(v == 0 ? "R8 timing with strobes while busy" : "R5 cycles to done",
               n, 2 * W * L + 1);
         check("R6 result bank even width", result_bank, 0);
         ref_sort();
         read_all(v == 0 ? "R8 result unaffected by strobes" : "R4 R7 sorted readout");
      end

      // R2: nine words wrap, the ninth overwrites address 0
      for (int i = 0; i < L + 1; i++) begin
         logic [W-1:0] w = W'(8'h90 - 8'(i * 13));
         if (i < L) ref_w[i] = w;
         else ref_w[0] = w;
         load(w);
      end
      run_sort(1'b0, n);
      check("R5 cycles on wrap data", n, 2 * W * L + 1);
      ref_sort();
      read_all("R2 load address wrap");

      // R2: a load after done restarts at address 0 of bank A
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h5A;
      @(negedge clk);
      in_valid = 1'b0;
      rd_addr = 3'd0;
      @(negedge clk);
      check("R2 load restarts at address 0", rd_data, 8'h5A);
      rd_addr = 3'd1;
      @(negedge clk);
      check("R2 neighbour untouched", rd_data, ref_w[1]);

      // odd width instance: result in bank B
      begin
         logic [OW-1:0] ov [OL] = '{3'd6, 3'd1, 3'd6, 3'd0};
         logic [OW-1:0] oe [OL] = '{3'd0, 3'd1, 3'd6, 3'd6};
         int m;
         for (int i = 0; i < OL; i++) begin
            @(negedge clk);
            o_valid = 1'b1; o_data = ov[i];
         end
         @(negedge clk);
         o_valid = 1'b0; o_start = 1'b1;
         @(negedge clk);
         o_start = 1'b0;
         m = 0;
         while (!o_done && m < 2000) begin
            @(posedge clk);
            m++;
            @(negedge clk);
         end
         check("R5 odd width cycles", m, 2 * OW * OL + 1);
         check("R6 result bank odd width", o_bank, 1);
         for (int a = 0; a < OL; a++) begin
            @(negedge clk);
            o_addr = a[1:0];
            @(negedge clk);
            check("R4 odd width sorted readout", o_rd, oe[a]);
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule